// File: doc/BRIEF.md
# Interrupt Routing and End-of-Interrupt Engine

This block watches a set of interrupt lines, one per pin, and turns them into delivery messages for downstream interrupt receivers. Every pin owns a routing entry that gives the line's active sense, whether it is edge- or level-sensitive, a mask, the vector number, the destination, the destination addressing kind and the delivery kind. Each line is compared every cycle with its registered history, so edges are found against the previous cycle's effective level. A pin that needs service raises an internal request. A fixed-priority picker takes the lowest-numbered request and loads it into a message register. That register drives a valid/ready stream.

Level-sensitive pins use a per-pin remote-pending flag. The flag is set when a request is raised, and while it is set the pin cannot raise another request. It is cleared by an end-of-interrupt broadcast of level type that carries the pin's vector. If the line is still active at that point, the pin is requested again. Each rising event is reported as accepted or coalesced. Every entry whose vector matches an end-of-interrupt gets a notification pulse. A 256-bit set of the vectors currently programmed in the table is kept as an output. Entries are loaded through a plain one-entry write port.

Back-pressure rules for the delivery stream: once `dlv_valid` is high it stays high, and every message field stays unchanged, until a cycle in which `dlv_ready` is also high. One message is transferred per such cycle. While the stream is stalled, pending requests wait in their per-pin request bits.

Top module: `irq_route_engine`

## Requirements
- R1: A pin's effective level is its raw line XOR the entry's active-low bit (entry bit 12). Every rule below uses the effective level.
- R2: An edge pin (entry bit 13 = 0) raises a request only when its effective level is 1 and was 0 in the previous cycle. An edge pin never sets its remote-pending flag, and holding the line active produces no further messages.
- R3: A level pin (bit 13 = 1) raises a request whenever its effective level is 1, it is unmasked and its remote-pending flag is 0. Raising the request sets the flag. While the flag is set, the pin produces no further messages.
- R4: A masked pin (bit 14 = 1) raises no request and produces no message. A rising event on a masked pin is reported as neither accepted nor coalesced, unless it is a level pin whose flag is still set.
- R5: Message fields are taken from the pin's entry. The entry layout, MSB first, is dest[22:15], mask[14], level[13], active_low[12], logical[11], mode[10:8], vector[7:0]. When several requests are pending, the lowest pin index is sent first.
- R6: While `dlv_valid` is 1 and `dlv_ready` is 0, valid stays 1 and all message fields hold. Each handshake transfers exactly one message.
- R7: An end-of-interrupt with vector V pulses `eoi_hit[i]` one cycle later for every pin i whose entry vector equals V, and for no other pin.
- R8: A level-type end-of-interrupt clears the remote-pending flag of every matching pin. A matching pin that is unmasked and still active is then sent again. An edge-type end-of-interrupt leaves the flags unchanged.
- R9: Writing an entry clears that pin's remote-pending flag and any request it still has queued. The pin's evaluation waits one cycle and then uses the new entry, so a level pin that is still active is served right after the rewrite.
- R10: `handled_vec[v]` is 1 exactly when some entry, masked or not, holds vector v. After reset every entry is masked with vector 0.
- R11: One cycle after a rising effective event, `irq_accepted` pulses if the event raised a new request. `irq_coalesced` pulses instead if the pin is level-sensitive with its flag set, or is unmasked with a request still queued. The two never pulse together.
- R12: After reset `dlv_valid` is 0, all flags and reports are 0 and `handled_vec` equals 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | NUM_PINS | Raw interrupt lines |
| tbl_we | input | 1 | Routing entry write strobe |
| tbl_idx | input | IDX_W | Pin index for the write |
| tbl_wdata | input | 23 | New entry (layout in R5) |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| eoi_level | input | 1 | 1 = level-type end-of-interrupt |
| dlv_valid | output | 1 | Delivery message valid |
| dlv_ready | input | 1 | Downstream accepts message |
| dlv_pin | output | IDX_W | Source pin of the message |
| dlv_vector | output | 8 | Vector |
| dlv_dest | output | 8 | Destination |
| dlv_logical | output | 1 | Destination addressing kind |
| dlv_mode | output | 3 | Delivery kind |
| dlv_level | output | 1 | Pin is level-sensitive |
| irq_accepted | output | NUM_PINS | Accept pulse per pin |
| irq_coalesced | output | NUM_PINS | Coalesce pulse per pin |
| eoi_hit | output | NUM_PINS | End-of-interrupt match pulse per pin |
| remote_irr | output | NUM_PINS | Remote-pending flags |
| handled_vec | output | 256 | Set of programmed vectors |

## Verification
Two functions can land on the same pin in the same cycle: the message stream holding a pin's request while it is stalled, and a second rising event on that pin. The bench holds `dlv_ready` low with two pins queued, then toggles the higher pin's line. It expects a coalesce pulse, one message per pin in index order, and message fields that do not move during the stall. A second overlap is a level-type end-of-interrupt arriving for a pin whose line is still active. Here the bench expects the flag to read 0 one cycle later and then a single fresh message. Random trials on random pins and entries are judged by bench functions derived from the requirements.

// File: rtl/irt_pkg.sv
package irt_pkg;
  localparam int VEC_W   = 8;
  localparam int DEST_W  = 8;
  localparam int MODE_W  = 3;
  localparam int NUM_VEC = 1 << VEC_W;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              level;
    logic              active_low;
    logic              logical;
    logic [MODE_W-1:0] dmode;
    logic [VEC_W-1:0]  vector;
  } irt_entry_t;

  localparam int ENT_W = $bits(irt_entry_t);

  localparam irt_entry_t ENT_RESET = '{
    dest: '0, mask: 1'b1, level: 1'b0, active_low: 1'b0,
    logical: 1'b0, dmode: '0, vector: '0
  };
endpackage

// File: rtl/irt_pin_slice.sv
module irt_pin_slice
  import irt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic             wr_i,
  input  irt_entry_t       wr_entry_i,
  input  logic             grant_i,
  input  logic             eoi_valid_i,
  input  logic [VEC_W-1:0] eoi_vector_i,
  input  logic             eoi_level_i,
  output irt_entry_t       entry_o,
  output logic             req_o,
  output logic             rirr_o,
  output logic             acc_o,
  output logic             coal_o,
  output logic             eoi_hit_o
);
  irt_entry_t ent_q;
  logic pend_q, req_q, rirr_q;
  logic eff, rise, edge_trig, lvl_trig, new_req, req_busy, eoi_match, blocked;

  always_comb begin
    eff       = line_i ^ ent_q.active_low;
    rise      = eff & ~pend_q;
    edge_trig = ~ent_q.level & rise & ~ent_q.mask;
    lvl_trig  = ent_q.level & eff & ~rirr_q & ~ent_q.mask & ~wr_i;
    new_req   = ~wr_i & (edge_trig | lvl_trig);
    req_busy  = req_q & ~grant_i;
    blocked   = ent_q.level & rirr_q;
    eoi_match = eoi_valid_i && (ent_q.vector == eoi_vector_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q     <= ENT_RESET;
      pend_q    <= 1'b0;
      req_q     <= 1'b0;
      rirr_q    <= 1'b0;
      acc_o     <= 1'b0;
      coal_o    <= 1'b0;
      eoi_hit_o <= 1'b0;
    end else begin
      eoi_hit_o <= eoi_match;
      if (wr_i) begin
        ent_q  <= wr_entry_i;
        req_q  <= 1'b0;
        rirr_q <= 1'b0;
        acc_o  <= 1'b0;
        coal_o <= 1'b0;
      end else begin
        pend_q <= eff;
        req_q  <= req_busy | new_req;
        if (lvl_trig)
          rirr_q <= 1'b1;
        else if (eoi_match && eoi_level_i)
          rirr_q <= 1'b0;
        acc_o  <= rise & ~ent_q.mask & ~blocked & ~req_busy;
        coal_o <= rise & (blocked | (~ent_q.mask & req_busy));
      end
    end
  end

  assign entry_o = ent_q;
  assign req_o   = req_q;
  assign rirr_o  = rirr_q;

  // R11: accept and coalesce are exclusive
  a_r11_acc_coal_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_o && coal_o));
  // R4: a masked pin never raises a request
  a_r4_mask_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    ent_q.mask |=> !$rose(req_q));
  // R2: edge pins never hold the remote-pending flag
  a_r2_edge_no_rirr: assert property (@(posedge clk) disable iff (!rst_n)
    (!ent_q.level && !wr_i) |=> !rirr_q);
  // R8: level-type end-of-interrupt clears a matching flag
  a_r8_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_match && eoi_level_i && !lvl_trig) |=> !rirr_q);
endmodule

// File: rtl/irt_prio_pick.sv
module irt_prio_pick #(
  parameter int N     = 24,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     onehot_o
);
  always_comb begin
    idx_o    = '0;
    onehot_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o    = IDX_W'(i);
        onehot_o = N'(1) << i;
      end
    end
    any_o = |req_i;
  end

  // R5: at most one pin picked, and it is a requesting one
  a_r5_pick_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(onehot_o) && ((onehot_o & ~req_i) == '0));
endmodule

// File: rtl/irt_msg_reg.sv
module irt_msg_reg
  import irt_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_i,
  input  logic [IDX_W-1:0] idx_i,
  input  irt_entry_t       entry_i,
  input  logic             ready_i,
  output logic             load_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] pin_o,
  output irt_entry_t       msg_o
);
  assign load_o = any_i && (!valid_o || ready_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      pin_o   <= '0;
      msg_o   <= ENT_RESET;
    end else if (load_o) begin
      valid_o <= 1'b1;
      pin_o   <= idx_i;
      msg_o   <= entry_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R6: a stalled message holds
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(msg_o) && $stable(pin_o)));
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
  import irt_pkg::*;
#(
  parameter  int NUM_PINS = 24,
  localparam int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  irq_line,
  input  logic                 tbl_we,
  input  logic [IDX_W-1:0]     tbl_idx,
  input  logic [ENT_W-1:0]     tbl_wdata,
  input  logic                 eoi_valid,
  input  logic [VEC_W-1:0]     eoi_vector,
  input  logic                 eoi_level,
  output logic                 dlv_valid,
  input  logic                 dlv_ready,
  output logic [IDX_W-1:0]     dlv_pin,
  output logic [VEC_W-1:0]     dlv_vector,
  output logic [DEST_W-1:0]    dlv_dest,
  output logic                 dlv_logical,
  output logic [MODE_W-1:0]    dlv_mode,
  output logic                 dlv_level,
  output logic [NUM_PINS-1:0]  irq_accepted,
  output logic [NUM_PINS-1:0]  irq_coalesced,
  output logic [NUM_PINS-1:0]  eoi_hit,
  output logic [NUM_PINS-1:0]  remote_irr,
  output logic [NUM_VEC-1:0]   handled_vec
);
  irt_entry_t ent [NUM_PINS];
  irt_entry_t wr_entry, pick_entry, msg;
  logic [NUM_PINS-1:0] req, pick_oh, grant;
  logic [IDX_W-1:0]    pick_idx;
  logic                pick_any, load;

  assign wr_entry = irt_entry_t'(tbl_wdata);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    irt_pin_slice u_slice (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_i       (irq_line[g]),
      .wr_i         (tbl_we && (tbl_idx == IDX_W'(g))),
      .wr_entry_i   (wr_entry),
      .grant_i      (grant[g]),
      .eoi_valid_i  (eoi_valid),
      .eoi_vector_i (eoi_vector),
      .eoi_level_i  (eoi_level),
      .entry_o      (ent[g]),
      .req_o        (req[g]),
      .rirr_o       (remote_irr[g]),
      .acc_o        (irq_accepted[g]),
      .coal_o       (irq_coalesced[g]),
      .eoi_hit_o    (eoi_hit[g])
    );
  end

  irt_prio_pick #(.N(NUM_PINS), .IDX_W(IDX_W)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req),
    .any_o    (pick_any),
    .idx_o    (pick_idx),
    .onehot_o (pick_oh)
  );

  assign pick_entry = ent[pick_idx];
  assign grant      = load ? pick_oh : '0;

  irt_msg_reg #(.IDX_W(IDX_W)) u_msg (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_i   (pick_any),
    .idx_i   (pick_idx),
    .entry_i (pick_entry),
    .ready_i (dlv_ready),
    .load_o  (load),
    .valid_o (dlv_valid),
    .pin_o   (dlv_pin),
    .msg_o   (msg)
  );

  assign dlv_vector  = msg.vector;
  assign dlv_dest    = msg.dest;
  assign dlv_logical = msg.logical;
  assign dlv_mode    = msg.dmode;
  assign dlv_level   = msg.level;

  always_comb begin
    handled_vec = '0;
    for (int i = 0; i < NUM_PINS; i++)
      handled_vec[ent[i].vector] = 1'b1;
  end

  // R10: the programmed-vector set is never empty
  a_r10_handled_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    handled_vec != '0);
  // R3: a level message leaves its pin's flag set while it waits
  a_r3_level_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (load && pick_entry.level && !tbl_we && !eoi_valid) |=> remote_irr[dlv_pin]);
endmodule

// File: tb/test_irq_route_engine.sv
`timescale 1ns/1ps
module test_irq_route_engine;
  localparam int N = 24;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_line = '0;
  logic tbl_we = 0; logic [4:0] tbl_idx = '0; logic [22:0] tbl_wdata = '0;
  logic eoi_valid = 0; logic [7:0] eoi_vector = '0; logic eoi_level = 0;
  logic dlv_valid, dlv_ready = 1; logic [4:0] dlv_pin;
  logic [7:0] dlv_vector, dlv_dest; logic dlv_logical, dlv_level; logic [2:0] dlv_mode;
  logic [N-1:0] irq_accepted, irq_coalesced, eoi_hit, remote_irr;
  logic [255:0] handled_vec;

  irq_route_engine i_irq_route_engine (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, dcount = 0;
  logic [4:0] pin_log [8];
  logic [4:0] l_pin; logic [7:0] l_vec, l_dest; logic l_log, l_lvl; logic [2:0] l_mode;
  logic [22:0] shadow [N];

  always @(posedge clk) begin
    if (rst_n && dlv_valid && dlv_ready) begin
      pin_log[dcount % 8] = dlv_pin;
      l_pin = dlv_pin; l_vec = dlv_vector; l_dest = dlv_dest;
      l_log = dlv_logical; l_lvl = dlv_level; l_mode = dlv_mode;
      dcount++;
    end
  end

  function automatic logic [22:0] mk(logic [7:0] dest, logic m, logic lv, logic al,
                                     logic lg, logic [2:0] md, logic [7:0] v);
    return {dest, m, lv, al, lg, md, v};
  endfunction

  function automatic logic [255:0] exp_handled();
    logic [255:0] h = '0;
    for (int i = 0; i < N; i++) h[shadow[i][7:0]] = 1'b1;
    return h;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic write_entry(int p, logic [22:0] e);
    tbl_we = 1; tbl_idx = 5'(p); tbl_wdata = e;
    @(negedge clk);
    tbl_we = 0; shadow[p] = e;
  endtask

  task automatic eoi_pulse(logic [7:0] v, logic lv);
    eoi_valid = 1; eoi_vector = v; eoi_level = lv;
    @(negedge clk);
    eoi_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; irq_line = '0; dlv_ready = 1;
    for (int i = 0; i < N; i++) shadow[i] = 23'h004000;
    tick(3); rst_n = 1; tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int c0;
    void'($urandom(32'd1957));
    do_reset();
    // R12 / R10 reset state
    check("R12 valid", dlv_valid, 0);
    check("R12 rirr", remote_irr, 0);
    check("R10 handled reset", handled_vec == 256'h1, 1);

    // R1 R2: active-low edge pin
    irq_line[2] = 1;
    write_entry(2, mk(8'h12, 0, 0, 1, 1, 3'd5, 8'h22));
    tick(2); c0 = dcount;
    irq_line[2] = 0; tick(1);
    check("R11 acc active-low", irq_accepted[2], 1);
    tick(5);
    check("R1 one msg", dcount, c0 + 1);
    check("R5 vec", l_vec, 8'h22);
    check("R5 dest", l_dest, 8'h12);
    check("R5 mode", {l_log, l_mode}, 4'hD);
    tick(5);
    check("R2 no repeat", dcount, c0 + 1);
    check("R2 edge flag", remote_irr[2], 0);

    // R4 masked edge pin
    write_entry(7, mk(8'h1, 1, 0, 0, 0, 3'd0, 8'h30));
    tick(1); c0 = dcount;
    irq_line[7] = 1; tick(1);
    check("R4 no acc", {irq_accepted[7], irq_coalesced[7]}, 0);
    tick(5);
    check("R4 no msg", dcount, c0);

    // R3 R7 R8: level pin with remote flag
    write_entry(5, mk(8'h55, 0, 1, 0, 0, 3'd1, 8'h41));
    tick(1); c0 = dcount;
    irq_line[5] = 1; tick(1);
    check("R11 acc level", irq_accepted[5], 1);
    check("R3 flag set", remote_irr[5], 1);
    tick(5);
    check("R3 one msg", dcount, c0 + 1);
    check("R5 level bit", l_lvl, 1);
    irq_line[5] = 0; tick(1); irq_line[5] = 1; tick(1);
    check("R11 coalesced", irq_coalesced[5], 1);
    tick(5);
    check("R3 no redelivery", dcount, c0 + 1);
    eoi_pulse(8'h42, 1);
    check("R7 no hit", eoi_hit, 0);
    check("R8 flag kept", remote_irr[5], 1);
    eoi_pulse(8'h41, 0);
    check("R7 hit edge-type", eoi_hit[5], 1);
    check("R8 edge-type keeps flag", remote_irr[5], 1);
    eoi_pulse(8'h41, 1);
    check("R7 hit level", eoi_hit, 24'h20);
    check("R8 flag cleared", remote_irr[5], 0);
    tick(5);
    check("R8 redelivered", dcount, c0 + 2);
    check("R8 flag again", remote_irr[5], 1);

    // R9 rewrite of masked active level pin
    write_entry(11, mk(8'h9, 1, 1, 0, 0, 3'd0, 8'h60));
    irq_line[11] = 1; tick(5); c0 = dcount;
    check("R9 masked quiet", dcount, c0);
    write_entry(11, mk(8'h9, 0, 1, 0, 0, 3'd0, 8'h60));
    tick(6);
    check("R9 served after rewrite", dcount, c0 + 1);
    check("R9 pin", l_pin, 11);
    check("R9 flag", remote_irr[11], 1);
    write_entry(11, mk(8'h9, 1, 1, 0, 0, 3'd0, 8'h60));
    check("R9 flag cleared by write", remote_irr[11], 0);
    check("R10 handled", handled_vec == exp_handled(), 1);

    // R5 R6 R11: priority and stall
    write_entry(3, mk(8'h3, 0, 0, 0, 0, 3'd0, 8'h73));
    write_entry(9, mk(8'h9, 0, 0, 0, 0, 3'd0, 8'h79));
    tick(1); c0 = dcount; dlv_ready = 0;
    irq_line[3] = 1; irq_line[9] = 1; tick(2);
    check("R5 lowest first", {dlv_valid, dlv_pin}, {1'b1, 5'd3});
    irq_line[9] = 0; tick(1); irq_line[9] = 1; tick(1);
    check("R11 coalesced queued", irq_coalesced[9], 1);
    check("R6 held", {dlv_valid, dlv_pin, dlv_vector}, {1'b1, 5'd3, 8'h73});
    check("R6 no transfer", dcount, c0);
    dlv_ready = 1; tick(5);
    check("R6 two transfers", dcount, c0 + 2);
    check("R5 order", {pin_log[c0 % 8], pin_log[(c0 + 1) % 8]}, {5'd3, 5'd9});

    // random trials
    do_reset();
    for (int t = 0; t < 40; t++) begin
      int p; logic al, lv, m, lg; logic [7:0] v, d; logic [2:0] md;
      p = $urandom % N; al = 1'($urandom); lv = 1'($urandom);
      m = (($urandom % 4) == 0); v = 8'($urandom); d = 8'($urandom);
      lg = 1'($urandom); md = 3'($urandom);
      irq_line[p] = al;
      write_entry(p, mk(d, m, lv, al, lg, md, v));
      tick(2); c0 = dcount;
      irq_line[p] = ~al; tick(1);
      check("R11 rand acc", irq_accepted[p], !m);
      tick(5);
      check("R4 rand count", dcount, c0 + (m ? 0 : 1));
      if (!m) begin
        check("R5 rand fields", {l_pin, l_vec, l_dest, l_log, l_mode, l_lvl},
              {5'(p), v, d, lg, md, lv});
      end
      check("R3 rand flag", remote_irr[p], lv & !m);
      if (lv && !m) begin
        eoi_pulse(v, 1); tick(5);
        check("R8 rand redelivery", dcount, c0 + 2);
      end
      irq_line[p] = al; tick(1);
      eoi_pulse(v, 1); tick(1);
      check("R8 rand cleared", remote_irr[p], 0);
    end
    check("R10 rand handled", handled_vec == exp_handled(), 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule